// File: doc/BRIEF.md
# Privileged Performance Counter Read Unit

This block keeps two free-running 40-bit event counters and answers a counter-read instruction issued by the core. On every clock, each counter advances by one when its own event strobe is high. Each counter wraps from all ones back to zero. Privileged software can load either counter with any value, including zero, through a write port.

A read request brings a 32-bit selector, the requester's privilege level and an image of the control register that holds the user-read enable. One cycle later the block answers. It either returns the selected count, split into a high word and a low word, or it flags a general-protection fault. The fault handler and the event selection are outside the block.

Top module: `pmc_read_unit`

## Requirements
- R1: After reset both counters read as zero, and `rsp_valid`, `rsp_fault`, `rsp_hi` and `rsp_lo` are all zero.
- R2: A counter whose `evt_en` bit is high in a cycle, and which is not written in that cycle, is one higher after the clock edge. A counter whose bit is low, and which is not written, keeps its value. The two counters are independent: `evt_en[0]` drives counter 0 and `evt_en[1]` drives counter 1.
- R3: A counter holding 40'hFF_FFFF_FFFF that counts an event becomes zero. It does not saturate.
- R4: When `wr_en` is high, the counter named by `wr_idx` (0 or 1) takes `wr_data` at the clock edge. The write wins over an event in the same cycle.
- R5: The selector decode compares all 32 bits. The value 0 selects counter 0 and the value 1 selects counter 1. Any other value, including one with only high-order bits set, gives a fault.
- R6: A read faults when `rd_cpl` is non-zero and bit 8 of `rd_ctl` is clear. A read at `rd_cpl` 0 never faults on privilege. A read at any level with bit 8 set never faults on privilege.
- R7: In a granted response, `rsp_lo` holds count bits 31:0. `rsp_hi` bits 7:0 hold count bits 39:32, and `rsp_hi` bits 31:8 are zero.
- R8: `rsp_valid` is high for exactly the one cycle that follows each cycle in which `rd_req` is high. The count returned is the value held before any increment or write that happens in the request cycle.
- R9: When `rsp_fault` is high, `rsp_valid` is high and both data words are zero.
- R10: Two reads of the same counter, with no write and no wrap between them, never return a smaller value for the later read.

Ports are listed in the order of the top module's port list.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| evt_en | input | 2 | Per-counter event strobe |
| wr_en | input | 1 | Counter load strobe |
| wr_idx | input | 1 | Counter to load |
| wr_data | input | 40 | Load value |
| rd_req | input | 1 | Read request |
| rd_sel | input | 32 | Counter selector |
| rd_cpl | input | 2 | Privilege level of the requester |
| rd_ctl | input | 32 | Control-register image; bit 8 is the user-read enable |
| rsp_valid | output | 1 | Response strobe |
| rsp_fault | output | 1 | General-protection fault |
| rsp_hi | output | 32 | Count bits 39:32, zero-extended |
| rsp_lo | output | 32 | Count bits 31:0 |

## Verification
The bound checker watches several rules on every cycle:
- the one-cycle response timing;
- the zero data on a fault;
- the zero padding of the high word;
- the fault and grant decision, from the selector and the privilege inputs;
- the increment, hold, wrap and load rules on each counter.

It also checks that the returned count equals the count held in the request cycle.

Other behaviours only show up in the bench's scenarios:
- that reads never go backwards across a sequence;
- that selectors with only high-order bits set fault;
- that a write racing an event leaves the written value;
- that the state after reset is seen through real reads.

A behavioural model compares every response against these scenarios and against a long random run.

// File: rtl/pmc_pkg.sv
package pmc_pkg;
  localparam int unsigned PMC_NUM     = 2;
  localparam int unsigned PMC_CNT_W   = 40;
  localparam int unsigned PMC_WORD_W  = 32;
  localparam int unsigned PMC_SEL_W   = 32;
  localparam int unsigned PMC_CPL_W   = 2;
  localparam int unsigned PMC_CTL_W   = 32;
  localparam int unsigned PMC_UEN_BIT = 8;

  typedef struct packed {
    logic                  valid;
    logic                  fault;
    logic [PMC_WORD_W-1:0] hi;
    logic [PMC_WORD_W-1:0] lo;
  } pmc_rsp_t;
endpackage

// File: rtl/pmc_counter.sv
module pmc_counter #(
  parameter int unsigned CNT_W = pmc_pkg::PMC_CNT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc_en,
  input  logic             load_en,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] count
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_ce;

  // load has priority over the event strobe; plain binary wrap
  always_comb begin
    cnt_ce = load_en | inc_en;
    cnt_d  = load_en ? load_val : cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_ce) begin
      cnt_q <= cnt_d;
    end
  end

  assign count = cnt_q;
endmodule

// File: rtl/pmc_access_check.sv
module pmc_access_check #(
  parameter int unsigned NUM     = pmc_pkg::PMC_NUM,
  parameter int unsigned SEL_W   = pmc_pkg::PMC_SEL_W,
  parameter int unsigned CPL_W   = pmc_pkg::PMC_CPL_W,
  parameter int unsigned IDX_W   = 1
) (
  input  logic [SEL_W-1:0] sel,
  input  logic [CPL_W-1:0] cpl,
  input  logic             user_en,
  output logic             grant,
  output logic [IDX_W-1:0] idx
);
  logic in_range;
  logic priv_ok;

  // every selector bit takes part in the range test
  always_comb begin
    in_range = (sel < SEL_W'(NUM));
    priv_ok  = (cpl == '0) || user_en;
    grant    = in_range && priv_ok;
    idx      = sel[IDX_W-1:0];
  end
endmodule

// File: rtl/pmc_read_unit.sv
module pmc_read_unit #(
  parameter  int unsigned NUM     = pmc_pkg::PMC_NUM,
  parameter  int unsigned CNT_W   = pmc_pkg::PMC_CNT_W,
  parameter  int unsigned WORD_W  = pmc_pkg::PMC_WORD_W,
  parameter  int unsigned SEL_W   = pmc_pkg::PMC_SEL_W,
  parameter  int unsigned CPL_W   = pmc_pkg::PMC_CPL_W,
  parameter  int unsigned CTL_W   = pmc_pkg::PMC_CTL_W,
  parameter  int unsigned UEN_BIT = pmc_pkg::PMC_UEN_BIT,
  localparam int unsigned IDX_W   = (NUM > 1) ? $clog2(NUM) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM-1:0]    evt_en,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [CNT_W-1:0]  wr_data,
  input  logic              rd_req,
  input  logic [SEL_W-1:0]  rd_sel,
  input  logic [CPL_W-1:0]  rd_cpl,
  input  logic [CTL_W-1:0]  rd_ctl,
  output logic              rsp_valid,
  output logic              rsp_fault,
  output logic [WORD_W-1:0] rsp_hi,
  output logic [WORD_W-1:0] rsp_lo
);
  localparam int unsigned HI_BITS = CNT_W - WORD_W;

  // reset: asserted asynchronously, released after two clock edges
  logic [1:0] rst_sync_q;
  logic       rst_n_sync;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_n_sync = rst_sync_q[1];

  // counters
  logic [CNT_W-1:0] cnt_q [NUM];

  for (genvar g = 0; g < NUM; g++) begin : g_ctr
    logic load_hit;
    assign load_hit = wr_en && (wr_idx == IDX_W'(g));
    pmc_counter #(.CNT_W(CNT_W)) u_ctr (
      .clk      (clk),
      .rst_n    (rst_n_sync),
      .inc_en   (evt_en[g]),
      .load_en  (load_hit),
      .load_val (wr_data),
      .count    (cnt_q[g])
    );
  end

  // access decision
  logic             grant;
  logic [IDX_W-1:0] sel_idx;
  logic             ctl_unused;

  assign ctl_unused = ^{rd_ctl[CTL_W-1:UEN_BIT+1], rd_ctl[UEN_BIT-1:0]};

  pmc_access_check #(
    .NUM   (NUM),
    .SEL_W (SEL_W),
    .CPL_W (CPL_W),
    .IDX_W (IDX_W)
  ) u_acc (
    .sel     (rd_sel),
    .cpl     (rd_cpl),
    .user_en (rd_ctl[UEN_BIT]),
    .grant   (grant),
    .idx     (sel_idx)
  );

  // response next-state and register
  pmc_pkg::pmc_rsp_t rsp_d;
  pmc_pkg::pmc_rsp_t rsp_q;
  logic [CNT_W-1:0]  cnt_pick;

  always_comb begin
    cnt_pick = cnt_q[sel_idx];
    rsp_d    = '0;
    if (rd_req) begin
      rsp_d.valid = 1'b1;
      if (grant) begin
        rsp_d.lo = cnt_pick[WORD_W-1:0];
        rsp_d.hi = {{(WORD_W-HI_BITS){1'b0}}, cnt_pick[CNT_W-1:WORD_W]};
      end else begin
        rsp_d.fault = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n_sync) begin
    if (!rst_n_sync) begin
      rsp_q <= '0;
    end else begin
      rsp_q <= rsp_d;
    end
  end

  assign rsp_valid = rsp_q.valid;
  assign rsp_fault = rsp_q.fault;
  assign rsp_hi    = rsp_q.hi;
  assign rsp_lo    = rsp_q.lo;
endmodule

// File: rtl/pmc_read_unit_chk.sv
module pmc_read_unit_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [1:0]  evt_en,
  input logic        wr_en,
  input logic        wr_idx,
  input logic [39:0] wr_data,
  input logic        rd_req,
  input logic [31:0] rd_sel,
  input logic [1:0]  rd_cpl,
  input logic        uen,
  input logic        rsp_valid,
  input logic        rsp_fault,
  input logic [31:0] rsp_hi,
  input logic [31:0] rsp_lo,
  input logic [39:0] cnt0,
  input logic [39:0] cnt1
);
  // R8
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> rsp_valid);
  // R8
  rsp_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_req |=> !rsp_valid);
  // R9
  fault_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_fault |-> (rsp_valid && rsp_hi == 32'd0 && rsp_lo == 32'd0));
  // R7
  hi_pad_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_hi[31:8] == 24'd0));
  // R5
  sel_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && rd_sel > 32'd1) |=> rsp_fault);
  // R6
  priv_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && rd_cpl != 2'd0 && !uen) |=> rsp_fault);
  // R6
  priv_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && rd_sel <= 32'd1 && (rd_cpl == 2'd0 || uen)) |=> !rsp_fault);
  // R8
  ctr0_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && rd_sel == 32'd0 && (rd_cpl == 2'd0 || uen))
      |=> ({rsp_hi[7:0], rsp_lo} == $past(cnt0)));
  // R8
  ctr1_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && rd_sel == 32'd1 && (rd_cpl == 2'd0 || uen))
      |=> ({rsp_hi[7:0], rsp_lo} == $past(cnt1)));
  // R2 R3
  ctr0_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_en[0] && !(wr_en && wr_idx == 1'b0)) |=> (cnt0 == $past(cnt0) + 40'd1));
  // R2 R3
  ctr1_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_en[1] && !(wr_en && wr_idx == 1'b1)) |=> (cnt1 == $past(cnt1) + 40'd1));
  // R2
  ctr0_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!evt_en[0] && !(wr_en && wr_idx == 1'b0)) |=> $stable(cnt0));
  // R2
  ctr1_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!evt_en[1] && !(wr_en && wr_idx == 1'b1)) |=> $stable(cnt1));
  // R4
  ctr0_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_idx == 1'b0) |=> (cnt0 == $past(wr_data)));
  // R4
  ctr1_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_idx == 1'b1) |=> (cnt1 == $past(wr_data)));
endmodule

bind pmc_read_unit pmc_read_unit_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n_sync),
  .evt_en    (evt_en),
  .wr_en     (wr_en),
  .wr_idx    (wr_idx),
  .wr_data   (wr_data),
  .rd_req    (rd_req),
  .rd_sel    (rd_sel),
  .rd_cpl    (rd_cpl),
  .uen       (rd_ctl[8]),
  .rsp_valid (rsp_valid),
  .rsp_fault (rsp_fault),
  .rsp_hi    (rsp_hi),
  .rsp_lo    (rsp_lo),
  .cnt0      (cnt_q[0]),
  .cnt1      (cnt_q[1])
);

// File: tb/sim_pmc_read_unit.sv
`timescale 1ns/1ps
module sim_pmc_read_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  evt_en;
  logic        wr_en;
  logic        wr_idx;
  logic [39:0] wr_data;
  logic        rd_req;
  logic [31:0] rd_sel;
  logic [1:0]  rd_cpl;
  logic [31:0] rd_ctl;
  logic        rsp_valid;
  logic        rsp_fault;
  logic [31:0] rsp_hi;
  logic [31:0] rsp_lo;

  always #4 clk = ~clk;

  pmc_read_unit u0 (
    .clk(clk), .rst_n(rst_n), .evt_en(evt_en), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_data(wr_data), .rd_req(rd_req), .rd_sel(rd_sel), .rd_cpl(rd_cpl),
    .rd_ctl(rd_ctl), .rsp_valid(rsp_valid), .rsp_fault(rsp_fault),
    .rsp_hi(rsp_hi), .rsp_lo(rsp_lo)
  );

  int n_tests = 0;
  int n_fail  = 0;

  // reference model
  bit [39:0] m_cnt [2];
  bit        e_valid;
  bit        e_fault;
  bit [31:0] e_hi;
  bit [31:0] e_lo;
  string     e_tag;

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic compare();
    check(rsp_valid === e_valid, "R8", "rsp_valid", {63'd0, rsp_valid}, {63'd0, e_valid});
    check(rsp_fault === (e_valid && e_fault), e_valid ? e_tag : "R8", "rsp_fault",
          {63'd0, rsp_fault}, {63'd0, e_fault});
    if (e_valid)
      check({rsp_hi, rsp_lo} === {e_hi, e_lo}, e_fault ? "R9" : "R7", "data",
            {rsp_hi, rsp_lo}, {e_hi, e_lo});
  endtask

  // one cycle: compare last response, drive new inputs, advance the model
  task automatic cyc(input bit [1:0] ev, input bit we, input bit widx,
                     input bit [39:0] wd, input bit rq, input bit [31:0] sel,
                     input bit [1:0] cpl, input bit uen);
    bit [31:0] ctl;
    @(negedge clk);
    compare();
    ctl    = $urandom;
    ctl[8] = uen;
    evt_en = ev; wr_en = we; wr_idx = widx; wr_data = wd;
    rd_req = rq; rd_sel = sel; rd_cpl = cpl; rd_ctl = ctl;
    e_valid = rq; e_fault = 1'b0; e_hi = '0; e_lo = '0; e_tag = "R6";
    if (rq) begin
      if (sel > 32'd1) begin
        e_fault = 1'b1; e_tag = "R5";
      end else if (cpl != 2'd0 && !uen) begin
        e_fault = 1'b1; e_tag = "R6";
      end else begin
        e_lo = m_cnt[sel[0]][31:0];
        e_hi = {24'd0, m_cnt[sel[0]][39:32]};
      end
    end
    for (int i = 0; i < 2; i++) begin
      if (we && widx == i[0]) m_cnt[i] = wd;
      else if (ev[i])         m_cnt[i] = m_cnt[i] + 40'd1;
    end
  endtask

  task automatic idle(input bit [1:0] ev);
    cyc(ev, 1'b0, 1'b0, 40'd0, 1'b0, 32'd0, 2'd0, 1'b0);
  endtask

  task automatic rd(input bit [1:0] ev, input bit [31:0] sel, input bit [1:0] cpl, input bit uen);
    cyc(ev, 1'b0, 1'b0, 40'd0, 1'b1, sel, cpl, uen);
  endtask

  function automatic bit [39:0] seen();
    return {rsp_hi[7:0], rsp_lo};
  endfunction

  initial begin
    #(8.0 * 200000);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    bit [39:0] v1;
    bit [39:0] v2;
    rst_n = 1'b0;
    evt_en = '0; wr_en = 0; wr_idx = 0; wr_data = '0;
    rd_req = 0; rd_sel = '0; rd_cpl = '0; rd_ctl = '0;
    m_cnt[0] = '0; m_cnt[1] = '0;
    e_valid = 0; e_fault = 0; e_hi = '0; e_lo = '0; e_tag = "R6";
    repeat (3) @(negedge clk);
    // R1 outputs in reset
    check(rsp_valid === 1'b0 && rsp_fault === 1'b0, "R1", "flags in reset",
          {62'd0, rsp_valid, rsp_fault}, 64'd0);
    check({rsp_hi, rsp_lo} === 64'd0, "R1", "data in reset", {rsp_hi, rsp_lo}, 64'd0);
    rst_n = 1'b1;
    repeat (3) idle(2'b00);

    // R1 counters read zero after reset
    rd(2'b00, 32'd0, 2'd0, 1'b0);
    rd(2'b00, 32'd1, 2'd0, 1'b0);
    check(seen() == 40'd0, "R1", "counter 0 after reset", {24'd0, seen()}, 64'd0);
    idle(2'b00);
    check(seen() == 40'd0, "R1", "counter 1 after reset", {24'd0, seen()}, 64'd0);

    // R2 independent counting
    repeat (5) idle(2'b01);
    repeat (3) idle(2'b10);
    repeat (2) idle(2'b11);
    rd(2'b00, 32'd0, 2'd0, 1'b0);
    rd(2'b00, 32'd1, 2'd0, 1'b0);
    check(seen() == 40'd7, "R2", "counter 0 count", {24'd0, seen()}, 64'd7);
    idle(2'b00);
    check(seen() == 40'd5, "R2", "counter 1 count", {24'd0, seen()}, 64'd5);

    // R4 write wins over an event; read in the write cycle sees old value
    cyc(2'b10, 1'b1, 1'b1, 40'h12_3456_789A, 1'b1, 32'd1, 2'd0, 1'b0);
    rd(2'b00, 32'd1, 2'd0, 1'b0);
    check(seen() == 40'd5, "R8", "read during write", {24'd0, seen()}, 64'd5);
    idle(2'b00);
    check(seen() == 40'h12_3456_789A, "R4", "write over event",
          {24'd0, seen()}, 64'h12_3456_789A);

    // R3 wrap
    cyc(2'b00, 1'b1, 1'b0, 40'hFF_FFFF_FFFE, 1'b0, 32'd0, 2'd0, 1'b0);
    rd(2'b01, 32'd0, 2'd0, 1'b0);
    rd(2'b01, 32'd0, 2'd0, 1'b0);
    rd(2'b00, 32'd0, 2'd0, 1'b0);
    idle(2'b00);
    check(seen() == 40'd0, "R3", "wrap to zero", {24'd0, seen()}, 64'd0);

    // R5 full-width selector decode
    rd(2'b00, 32'd2, 2'd0, 1'b1);
    rd(2'b00, 32'h8000_0000, 2'd0, 1'b1);
    rd(2'b00, 32'h0001_0000, 2'd0, 1'b1);
    rd(2'b00, 32'h0000_0101, 2'd0, 1'b1);
    rd(2'b00, 32'hFFFF_FFFF, 2'd0, 1'b1);
    idle(2'b00);
    check(rsp_fault === 1'b1, "R5", "all-ones selector", {63'd0, rsp_fault}, 64'd1);

    // R6 privilege combinations
    rd(2'b00, 32'd1, 2'd3, 1'b0);
    rd(2'b00, 32'd1, 2'd3, 1'b1);
    rd(2'b00, 32'd0, 2'd1, 1'b0);
    rd(2'b00, 32'd0, 2'd0, 1'b0);
    idle(2'b00);
    check(rsp_fault === 1'b0, "R6", "level 0 with enable clear", {63'd0, rsp_fault}, 64'd0);

    // R10 later read never smaller
    rd(2'b10, 32'd1, 2'd2, 1'b1);
    idle(2'b10);
    v1 = seen();
    repeat (4) idle(2'b10);
    rd(2'b10, 32'd1, 2'd2, 1'b1);
    idle(2'b00);
    v2 = seen();
    check(v2 >= v1, "R10", "second read not smaller", {24'd0, v2}, {24'd0, v1});

    // random traffic
    for (int n = 0; n < 3000; n++) begin
      bit [31:0] s;
      int        r;
      r = int'($urandom % 8);
      if (r < 3)       s = 32'd0;
      else if (r < 6)  s = 32'd1;
      else if (r == 6) s = $urandom;
      else             s = 32'd2;
      cyc(2'($urandom), ($urandom % 16) == 0, 1'($urandom),
          {8'($urandom), 32'($urandom)}, 1'($urandom), s,
          2'($urandom), 1'($urandom));
    end
    idle(2'b00);
    idle(2'b00);
    @(negedge clk);
    compare();

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule